// File: doc/BRIEF.md
# Max-Min Fair Share Allocator

This block splits one shared capacity among a fixed set of requesters so that the smallest requests are met in full and whatever is left is divided evenly among the rest. Demands and capacity are unsigned fixed-point numbers with 8 integer and 8 fraction bits. A one-cycle `start` pulse latches the demands and the capacity. The block then computes the shares over several cycles and raises `done` for one cycle when the allocations on `alloc_flat` are valid.

Inside, the latched demands pass through a compare-and-swap sorting network. The block then walks the sorted list from the smallest demand upward. At each step it divides the remaining capacity by the number of requesters not yet served, using a shift-subtract divider that handles one bit per cycle and truncates the quotient. If the current demand fits within that quotient, the requester gets its full demand, the demand is taken off the remainder, and the walk moves to the next requester. If it does not fit, that requester and every larger one each receive the same quotient, and the run ends. With demands 2, 2.6, 4 and 5 and a capacity of 10, the result is 2, 2.6, 2.7 and 2.7, within the truncation of 8.8 arithmetic.

Top module: `maxmin_alloc`

## Requirements
- R1: No requester is ever allocated more than its latched demand.
- R2: When the sum of demands is at most the capacity, every requester receives exactly its demand.
- R3: The sum of all allocations never exceeds the latched capacity.
- R4: Requesters whose demand is not met all receive the same value. That value is the truncated quotient of the capacity left after the smaller demands are met, divided by the number of requesters not yet served.
- R5: Demands 0x0200, 0x0299, 0x0400, 0x0500 (2, 2.6, 4, 5 in 8.8) with capacity 0x0A00 give allocations 0x0200, 0x0299, 0x02B3, 0x02B3.
- R6: `done` is high for exactly one cycle per run, and `busy` is high from the cycle after `start` until `done` rises.
- R7: After `done`, `alloc_flat` holds its value until the next accepted `start`.
- R8: After reset, `done` and `busy` are low and every allocation is zero.
- R9: A `start` pulse while `busy` is high is ignored. The running computation keeps the demands and capacity latched at its own start.
- R10: The allocation each requester receives depends only on its own demand and on the set of other demands, not on its position in the port. Ties are broken by position.
- R11: A capacity of zero gives every requester an allocation of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that latches inputs and begins a run |
| demand_flat | input | N*W | Demand of requester i in bits [i*W +: W], 8.8 unsigned |
| capacity | input | W | Capacity to share, 8.8 unsigned |
| alloc_flat | output | N*W | Allocation of requester i in bits [i*W +: W] |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: allocations are valid |

## Verification
The bench builds the block with its default four requesters and 16-bit values. At that size the sorting network has few enough positions to reverse the order of a directed case and to drive ties, and every path of the walk can be reached. The walk can stop at the first step, stop midway, or run all the way when everything fits. The 16-bit width lets random demands and capacities cross from under-subscribed to heavily over-subscribed, so the truncating divider runs with every divisor from one to four. Directed cases add zero capacity, zero demands, and a start pulse that arrives during a run.

// File: rtl/maxmin_alloc_pkg.sv
package maxmin_alloc_pkg;
    localparam int DEF_N = 4;
    localparam int DEF_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SORT = 2'd1,
        ST_WAIT = 2'd2
    } phase_e;
endpackage

// File: rtl/maxmin_sorter.sv
module maxmin_sorter #(
    parameter int N  = 4,
    parameter int W  = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][W-1:0]  val_i,
    output logic [N-1:0][W-1:0]  val_o,
    output logic [N-1:0][IW-1:0] idx_o
);
    logic [W-1:0]  sv [0:N][0:N-1];
    logic [IW-1:0] si [0:N][0:N-1];

    for (genvar i = 0; i < N; i++) begin : g_in
        assign sv[0][i] = val_i[i];
        assign si[0][i] = IW'(i);
        assign val_o[i] = sv[N][i];
        assign idx_o[i] = si[N][i];
    end

    for (genvar s = 0; s < N; s++) begin : g_stage
        for (genvar i = 0; i < N; i++) begin : g_lane
            if ((i % 2) == (s % 2) && (i + 1) < N) begin : g_pair
                logic swap;
                assign swap          = sv[s][i] > sv[s][i+1];
                assign sv[s+1][i]    = swap ? sv[s][i+1] : sv[s][i];
                assign si[s+1][i]    = swap ? si[s][i+1] : si[s][i];
                assign sv[s+1][i+1]  = swap ? sv[s][i]   : sv[s][i+1];
                assign si[s+1][i+1]  = swap ? si[s][i]   : si[s][i+1];
            end else if (i > 0 && ((i - 1) % 2) == (s % 2)) begin : g_upper
                // lane written by the pair below it
            end else begin : g_pass
                assign sv[s+1][i] = sv[s][i];
                assign si[s+1][i] = si[s][i];
            end
        end
    end
endmodule

// File: rtl/maxmin_divider.sv
module maxmin_divider #(
    parameter int W  = 16,
    parameter int DW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [W-1:0]  dividend,
    input  logic [DW-1:0] divisor,
    output logic [W-1:0]  quotient,
    output logic          ready
);
    localparam int RW = DW + 1;
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic [W-1:0]  work;
        logic [RW-1:0] part;
        logic [DW-1:0] dvs;
        logic          fin;
    } div_t;

    div_t q_q, q_d;
    logic [RW-1:0] trial;

    always_comb begin
        q_d     = q_q;
        q_d.fin = 1'b0;
        trial   = {q_q.part[RW-2:0], q_q.work[W-1]};
        if (go) begin
            q_d.run  = 1'b1;
            q_d.cnt  = CW'(W);
            q_d.work = dividend;
            q_d.part = '0;
            q_d.dvs  = divisor;
        end else if (q_q.run) begin
            if (trial >= RW'(q_q.dvs)) begin
                q_d.part = trial - RW'(q_q.dvs);
                q_d.work = {q_q.work[W-2:0], 1'b1};
            end else begin
                q_d.part = trial;
                q_d.work = {q_q.work[W-2:0], 1'b0};
            end
            q_d.cnt = q_q.cnt - 1'b1;
            if (q_q.cnt == CW'(1)) begin
                q_d.run = 1'b0;
                q_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign quotient = q_q.work;
    assign ready    = q_q.fin;
endmodule

// File: rtl/maxmin_alloc.sv
module maxmin_alloc
    import maxmin_alloc_pkg::*;
#(
    parameter int N = DEF_N,
    parameter int W = DEF_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N*W-1:0] demand_flat,
    input  logic [W-1:0]   capacity,
    output logic [N*W-1:0] alloc_flat,
    output logic           busy,
    output logic           done
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        phase_e              ph;
        logic [N-1:0][W-1:0] dem;
        logic [W-1:0]        cap;
        logic [N-1:0][W-1:0] sval;
        logic [N-1:0][IW-1:0] sidx;
        logic [W-1:0]        rem;
        logic [CW-1:0]       step;
        logic [N-1:0][W-1:0] alloc;
        logic                go;
        logic                fin;
    } st_t;

    st_t st_q, st_d;

    logic [N-1:0][W-1:0]  srt_val;
    logic [N-1:0][IW-1:0] srt_idx;
    logic [W-1:0]         quo;
    logic                 quo_rdy;
    logic [CW-1:0]        left_cnt;
    logic [W-1:0]         cur_val;
    logic [N*W-1:0]       dem_lat;
    logic [W-1:0]         cap_lat;

    maxmin_sorter #(.N(N), .W(W), .IW(IW)) u_sort (
        .val_i (st_q.dem),
        .val_o (srt_val),
        .idx_o (srt_idx)
    );

    assign left_cnt = CW'(N) - st_q.step;

    maxmin_divider #(.W(W), .DW(CW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (st_q.go),
        .dividend (st_q.rem),
        .divisor  (left_cnt),
        .quotient (quo),
        .ready    (quo_rdy)
    );

    assign cur_val = st_q.sval[st_q.step[IW-1:0]];

    always_comb begin
        st_d     = st_q;
        st_d.go  = 1'b0;
        st_d.fin = 1'b0;
        unique case (st_q.ph)
            ST_IDLE: begin
                if (start) begin
                    st_d.dem   = demand_flat;
                    st_d.cap   = capacity;
                    st_d.alloc = '0;
                    st_d.ph    = ST_SORT;
                end
            end
            ST_SORT: begin
                st_d.sval = srt_val;
                st_d.sidx = srt_idx;
                st_d.rem  = st_q.cap;
                st_d.step = '0;
                st_d.go   = 1'b1;
                st_d.ph   = ST_WAIT;
            end
            ST_WAIT: begin
                if (quo_rdy) begin
                    if (cur_val <= quo) begin
                        st_d.alloc[st_q.sidx[st_q.step[IW-1:0]]] = cur_val;
                        st_d.rem = st_q.rem - cur_val;
                        if (st_q.step == CW'(N - 1)) begin
                            st_d.ph  = ST_IDLE;
                            st_d.fin = 1'b1;
                        end else begin
                            st_d.step = st_q.step + 1'b1;
                            st_d.go   = 1'b1;
                        end
                    end else begin
                        for (int k = 0; k < N; k++) begin
                            if (CW'(k) >= st_q.step)
                                st_d.alloc[st_q.sidx[k]] = quo;
                        end
                        st_d.ph  = ST_IDLE;
                        st_d.fin = 1'b1;
                    end
                end
            end
            default: st_d.ph = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign alloc_flat = st_q.alloc;
    assign busy       = (st_q.ph != ST_IDLE);
    assign done       = st_q.fin;
    assign dem_lat    = st_q.dem;
    assign cap_lat    = st_q.cap;
endmodule

// File: rtl/maxmin_alloc_chk.sv
module maxmin_alloc_chk #(
    parameter int N = 4,
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [N*W-1:0] dem_lat,
    input logic [W-1:0]   cap_lat,
    input logic [N*W-1:0] alloc_flat
);
    localparam int SW = W + $clog2(N + 1);

    logic [SW-1:0] alloc_sum;
    logic          over_dem;

    always_comb begin
        alloc_sum = '0;
        over_dem  = 1'b0;
        for (int i = 0; i < N; i++) begin
            alloc_sum = alloc_sum + SW'(alloc_flat[i*W +: W]);
            if (alloc_flat[i*W +: W] > dem_lat[i*W +: W]) over_dem = 1'b1;
        end
    end

    a_r1_within_demand: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !over_dem);

    a_r3_within_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (alloc_sum <= SW'(cap_lat)));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r7_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && !$past(start)) |-> $stable(alloc_flat));

    a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(cap_lat) && $stable(dem_lat)));
endmodule

bind maxmin_alloc maxmin_alloc_chk #(.N(N), .W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .dem_lat    (dem_lat),
    .cap_lat    (cap_lat),
    .alloc_flat (alloc_flat)
);

// File: tb/test_maxmin_alloc.sv
module test_maxmin_alloc;
    localparam int N = 4;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N*W-1:0] demand_flat = '0;
    logic [W-1:0]   capacity = '0;
    logic [N*W-1:0] alloc_flat;
    logic           busy;
    logic           done;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    maxmin_alloc #(.N(N), .W(W)) i_maxmin_alloc (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .demand_flat (demand_flat),
        .capacity    (capacity),
        .alloc_flat  (alloc_flat),
        .busy        (busy),
        .done        (done)
    );

    // progressive filling by whole passes, taken from the requirements
    function automatic logic [N*W-1:0] ref_alloc(input logic [N*W-1:0] d, input logic [W-1:0] c);
        logic [N*W-1:0] a = '0;
        logic [N-1:0]   sat = '0;
        int rem = c;
        bit grew = 1'b1;
        while (grew) begin
            int k = 0;
            int share;
            grew = 1'b0;
            for (int i = 0; i < N; i++) if (!sat[i]) k++;
            if (k == 0) break;
            share = rem / k;
            for (int i = 0; i < N; i++) begin
                if (!sat[i] && int'(d[i*W +: W]) <= share) begin
                    sat[i] = 1'b1;
                    a[i*W +: W] = d[i*W +: W];
                    rem = rem - int'(d[i*W +: W]);
                    grew = 1'b1;
                end
            end
            if (!grew) begin
                for (int i = 0; i < N; i++) if (!sat[i]) a[i*W +: W] = W'(share);
            end
        end
        return a;
    endfunction

    task automatic check(input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [N*W-1:0] d, input logic [W-1:0] c, input string req,
                       input bit poke_busy);
        int cyc = 0;
        logic [N*W-1:0] exp = ref_alloc(d, c);
        logic [N*W-1:0] got;
        @(negedge clk);
        demand_flat = d;
        capacity    = c;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " R6 busy after start"}, N*W'(busy), N*W'(1));
        if (poke_busy) begin
            demand_flat = ~d;
            capacity    = ~c;
            start       = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL %s R6 watchdog: done %0d expected 1", req, done);
            return;
        end
        got = alloc_flat;
        check({req, poke_busy ? " R9" : ""}, got, exp);
        check({req, " R6 busy low at done"}, N*W'(busy), '0);
        @(negedge clk);
        check({req, " R6 done one cycle"}, N*W'(done), '0);
        repeat (3) @(negedge clk);
        check({req, " R7 hold"}, alloc_flat, got);
    endtask

    function automatic logic [N*W-1:0] pack4(input logic [W-1:0] a, b, e, f);
        return {f, e, b, a};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R8 reset alloc", alloc_flat, '0);
        check("R8 reset flags", N*W'({busy, done}), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 and R4: reference example
        run(pack4(16'h0200, 16'h0299, 16'h0400, 16'h0500), 16'h0A00, "R5", 1'b0);
        check("R5 literal", alloc_flat, pack4(16'h0200, 16'h0299, 16'h02B3, 16'h02B3));
        check("R4 equal unmet shares", N*W'(alloc_flat[2*W +: W] == alloc_flat[3*W +: W]), N*W'(1));
        // R10: reversed order
        run(pack4(16'h0500, 16'h0400, 16'h0299, 16'h0200), 16'h0A00, "R10", 1'b0);
        check("R10 literal", alloc_flat, pack4(16'h02B3, 16'h02B3, 16'h0299, 16'h0200));
        // R2: fits
        run(pack4(16'h0100, 16'h0300, 16'h0050, 16'h0200), 16'h0650, "R2", 1'b0);
        check("R2 literal", alloc_flat, pack4(16'h0100, 16'h0300, 16'h0050, 16'h0200));
        // R11: zero capacity
        run(pack4(16'h0100, 16'h0000, 16'h0700, 16'hFFFF), 16'h0000, "R11", 1'b0);
        check("R11 literal", alloc_flat, '0);
        // R4: all equal ties, over-subscribed
        run(pack4(16'h0800, 16'h0800, 16'h0800, 16'h0800), 16'h0A01, "R4 ties", 1'b0);
        check("R4 ties literal", alloc_flat, pack4(16'h0280, 16'h0280, 16'h0280, 16'h0280));
        // R9: start during busy
        run(pack4(16'h0200, 16'h0299, 16'h0400, 16'h0500), 16'h0A00, "R9 poke", 1'b1);
        // R1 R3: random
        for (int t = 0; t < 60; t++) begin
            logic [N*W-1:0] d;
            for (int i = 0; i < N; i++) d[i*W +: W] = W'($urandom_range(0, 3000));
            run(d, W'($urandom_range(0, 9000)), "R1 R3 random", 1'b0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL R6 global watchdog: done %0d expected 1", done);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule